// File: doc/BRIEF.md
# GPIO Controller with Parallel Level and Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for up to 32 pins. Each pin has an output value and an output enable that software programs, and an input that is brought into the clock domain through a two-flop synchronizer. The synchronized levels are readable and also feed two interrupt paths that run side by side. The level path flags a pin whose synchronized level, after an optional inversion, is high. The edge path latches a rising or falling transition into a sticky event register that software clears by writing ones.

Every pin has its own polarity and mask bit in each path. The pending sources of all pins are ORed into one top-level status bit. A top-level mask bit gates that status into a two-state interrupt machine, which drives a single registered, active-high interrupt line. The host reaches the registers over a plain synchronous bus with address, write enable, write data, read enable and registered read data.

The interrupt machine has two states. `IRQ_IDLE` is the reset state with the line low. It takes the transition `RAISE` to `IRQ_ACTIVE` on a clock edge where the status bit and the top mask bit are both 1. `IRQ_ACTIVE` drives the line high and takes the transition `DROP` back to `IRQ_IDLE` on a clock edge where either of them is 0.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_oe` and `pin_out` are 0 and `irq` is 0.
- R2: The data-out register (offset 0x44) drives `pin_out` and the output-enable register (offset 0x48) drives `pin_oe`. A 1 in an enable bit means that pin drives its data-out bit. Both ports change on the clock edge that takes the write.
- R3: The data-in register (offset 0x40) returns the pin levels after two synchronizer flops. In every register, bits at or above `NUM_PINS` read as 0 and ignore writes.
- R4: A pin's level source is pending when (data-in XOR level-polarity) AND level-mask is 1. The level polarity is at 0x50 and the level mask at 0x54, so a polarity bit of 1 means active-low.
- R5: A pin's edge-polarity bit (0x64) selects rising detection when 0 and falling detection when 1. A detected edge sets that pin's bit in the event register (0x58) whatever the pin's edge-mask bit (0x5c).
- R6: Writing 1 to an event bit clears it, and writing 0 leaves it unchanged. When a new edge and a clearing write hit the same bit in the same cycle, the bit stays set.
- R7: Bit 0 of the top status register (0x00) is 1 exactly when some pin has a pending level source, or has an event bit and an edge-mask bit both set. The register ignores writes.
- R8: `irq` rises on the clock edge after bit 0 of status and bit 0 of the top mask register (0x04) are both 1 (`RAISE`). It falls on the clock edge after either of them is 0 (`DROP`).
- R9: `bus_rdata` is loaded on the clock edge that samples `bus_re` and holds its value otherwise. Unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Raw pin levels, asynchronous |
| pin_out | output | NUM_PINS | Output values |
| pin_oe | output | NUM_PINS | Output enables, 1 = drive |
| irq | output | 1 | Interrupt line, active high |

## Verification
The checker assumes that the bus strobes and address are known on every clock edge after reset, and that an event-register write comes only from `bus_we` at offset 0x58. From this it derives which event bits may legally clear. It makes no assumption about when `pin_in` toggles. The bench still changes pins and bus signals only on falling clock edges. It waits at least three cycles after a pin change before it relies on the synchronized value, except in the one test that deliberately lands a clearing write on the edge-capture cycle. The bench drives pins low through reset, so the synchronizer starts from a settled state.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int AW = 8;
    localparam int DW = 32;

    localparam logic [AW-1:0] OFS_TOP_STAT = 8'h00;
    localparam logic [AW-1:0] OFS_TOP_MASK = 8'h04;
    localparam logic [AW-1:0] OFS_DIN      = 8'h40;
    localparam logic [AW-1:0] OFS_DOUT     = 8'h44;
    localparam logic [AW-1:0] OFS_OE       = 8'h48;
    localparam logic [AW-1:0] OFS_LVL_POL  = 8'h50;
    localparam logic [AW-1:0] OFS_LVL_MASK = 8'h54;
    localparam logic [AW-1:0] OFS_EVT      = 8'h58;
    localparam logic [AW-1:0] OFS_EVT_MASK = 8'h5c;
    localparam logic [AW-1:0] OFS_EVT_POL  = 8'h64;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= raw_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_latch.sv
module gpio_edge_latch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] falling_sel,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] events
);
    for (genvar p = 0; p < W; p++) begin : g_pin
        logic prev_q;
        logic evt_q;
        logic hit;

        assign hit = falling_sel[p] ? (prev_q & ~level[p])
                                    : (~prev_q & level[p]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                evt_q  <= 1'b0;
            end else begin
                prev_q <= level[p];
                // a fresh edge outranks a same-cycle clear
                evt_q  <= hit | (evt_q & ~clr_bits[p]);
            end
        end

        assign events[p] = evt_q;
    end
endmodule

// File: rtl/gpio_irq_fsm.sv
module gpio_irq_fsm
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    output logic irq
);
    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (armed)  state_d = IRQ_ACTIVE;   // RAISE
            IRQ_ACTIVE: if (!armed) state_d = IRQ_IDLE;     // DROP
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_ACTIVE);
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       bus_addr,
    input  logic                bus_we,
    input  logic [DW-1:0]       bus_wdata,
    input  logic                bus_re,
    output logic [DW-1:0]       bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int N = NUM_PINS;

    logic [N-1:0] dout_q, oe_q, lpol_q, lmask_q, emask_q, epol_q;
    logic         top_mask_q;
    logic [N-1:0] din_s, evt_bits, evt_clr;
    logic [N-1:0] lvl_pend, edge_pend;
    logic         status;
    logic [DW-1:0] rd_mux;

    gpio_in_sync #(.W(N), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .sync_out (din_s)
    );

    assign evt_clr = (bus_we && bus_addr == OFS_EVT) ? bus_wdata[N-1:0] : '0;

    gpio_edge_latch #(.W(N)) u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .level       (din_s),
        .falling_sel (epol_q),
        .clr_bits    (evt_clr),
        .events      (evt_bits)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q     <= '0;
            oe_q       <= '0;
            lpol_q     <= '0;
            lmask_q    <= '0;
            emask_q    <= '0;
            epol_q     <= '0;
            top_mask_q <= 1'b0;
        end else if (bus_we) begin
            unique case (bus_addr)
                OFS_TOP_MASK: top_mask_q <= bus_wdata[0];
                OFS_DOUT:     dout_q     <= bus_wdata[N-1:0];
                OFS_OE:       oe_q       <= bus_wdata[N-1:0];
                OFS_LVL_POL:  lpol_q     <= bus_wdata[N-1:0];
                OFS_LVL_MASK: lmask_q    <= bus_wdata[N-1:0];
                OFS_EVT_MASK: emask_q    <= bus_wdata[N-1:0];
                OFS_EVT_POL:  epol_q     <= bus_wdata[N-1:0];
                default: ;
            endcase
        end
    end

    assign lvl_pend  = (din_s ^ lpol_q) & lmask_q;
    assign edge_pend = evt_bits & emask_q;
    assign status    = |(lvl_pend | edge_pend);

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            OFS_TOP_STAT: rd_mux[0]     = status;
            OFS_TOP_MASK: rd_mux[0]     = top_mask_q;
            OFS_DIN:      rd_mux[N-1:0] = din_s;
            OFS_DOUT:     rd_mux[N-1:0] = dout_q;
            OFS_OE:       rd_mux[N-1:0] = oe_q;
            OFS_LVL_POL:  rd_mux[N-1:0] = lpol_q;
            OFS_LVL_MASK: rd_mux[N-1:0] = lmask_q;
            OFS_EVT:      rd_mux[N-1:0] = evt_bits;
            OFS_EVT_MASK: rd_mux[N-1:0] = emask_q;
            OFS_EVT_POL:  rd_mux[N-1:0] = epol_q;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux;
    end

    gpio_irq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .armed (status & top_mask_q),
        .irq   (irq)
    );

    assign pin_out = dout_q;
    assign pin_oe  = oe_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int N = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_we,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic          top_mask,
    input logic          status,
    input logic [N-1:0]  evt,
    input logic          irq
);
    logic [N-1:0] clr_seen;
    assign clr_seen = (bus_we && bus_addr == OFS_EVT) ? bus_wdata[N-1:0] : '0;

    // R8
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status && top_mask) |=> irq);

    // R8
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(status && top_mask) |=> !irq);

    // R6
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(evt) & ~$past(clr_seen)) & ~evt) == '0));

    if (N < DW) begin : g_pad
        // R3
        rdata_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rdata[DW-1:N] == '0);
    end
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .top_mask  (top_mask_q),
    .status    (status),
    .evt       (evt_bits),
    .irq       (irq)
);

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
    localparam int NP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_re = 1'b0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    gpio_irq_ctrl #(.NUM_PINS(NP)) u_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // {offset, write data, expected readback}
    localparam logic [71:0] VEC [15] = '{
        {8'h44, 32'hFFFF_FFFF, 32'h0000_FFFF},
        {8'h44, 32'h0000_00A5, 32'h0000_00A5},
        {8'h48, 32'h1234_5678, 32'h0000_5678},
        {8'h50, 32'hFFFF_0003, 32'h0000_0003},
        {8'h54, 32'h0000_0000, 32'h0000_0000},
        {8'h5c, 32'h0001_8001, 32'h0000_8001},
        {8'h64, 32'hABCD_0000, 32'h0000_0000},
        {8'h04, 32'hFFFF_FFFF, 32'h0000_0001},
        {8'h04, 32'h0000_0000, 32'h0000_0000},
        {8'h00, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'h20, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'h48, 32'h0000_0000, 32'h0000_0000},
        {8'h44, 32'h0000_0000, 32'h0000_0000},
        {8'h5c, 32'h0000_0000, 32'h0000_0000},
        {8'h50, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    logic [31:0] r;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 pin_oe", {16'b0, pin_oe}, 32'h0);
        check("R1 pin_out", {16'b0, pin_out}, 32'h0);
        rd(8'h48, r); check("R1 oe reg", r, 32'h0);
        rd(8'h58, r); check("R1 event reg", r, 32'h0);
        rd(8'h04, r); check("R1 top mask", r, 32'h0);
        rd(8'h00, r); check("R1 top status", r, 32'h0);

        // R2 R3 R9: register table, upper bits dropped, unmapped reads 0
        for (int i = 0; i < 15; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], r);
            check("R3/R9 table readback", r, VEC[i][31:0]);
        end

        // R2: pin drive follows registers on the write edge
        wr(8'h44, 32'h0000_00A5);
        check("R2 pin_out", {16'b0, pin_out}, 32'h0000_00A5);
        wr(8'h48, 32'h0000_000F);
        check("R2 pin_oe", {16'b0, pin_oe}, 32'h0000_000F);

        // R3: synchronized input readback
        @(negedge clk); pin_in = 16'h3C5A;
        settle(4);
        rd(8'h40, r); check("R3 data in", r, 32'h0000_3C5A);

        // R5: rising edges latch with edge mask clear
        rd(8'h58, r); check("R5 rising events", r, 32'h0000_3C5A);
        // R6: ones clear, zeros keep
        wr(8'h58, 32'h0000_000F);
        rd(8'h58, r); check("R6 partial clear", r, 32'h0000_3C50);
        wr(8'h58, 32'hFFFF_FFFF);
        rd(8'h58, r); check("R6 full clear", r, 32'h0);

        // R4 R7: level path, pin0 is low
        wr(8'h54, 32'h0000_0001);
        rd(8'h00, r); check("R4 active-high pin low", r, 32'h0);
        wr(8'h50, 32'h0000_0001);
        rd(8'h00, r); check("R4 active-low pin low", r, 32'h1);
        check("R8 gated by top mask", {31'b0, irq}, 32'h0);

        // R8: RAISE one edge after arming, DROP one edge after disarming
        wr(8'h04, 32'h0000_0001);
        check("R8 not yet raised", {31'b0, irq}, 32'h0);
        settle(1);
        check("R8 raised", {31'b0, irq}, 32'h1);
        wr(8'h54, 32'h0);
        check("R8 not yet dropped", {31'b0, irq}, 32'h1);
        settle(1);
        check("R8 dropped", {31'b0, irq}, 32'h0);

        // R5: falling select on pin1
        wr(8'h64, 32'h0000_0002);
        @(negedge clk); pin_in = 16'h3C58;
        settle(4);
        rd(8'h58, r); check("R5 falling event", r, 32'h0000_0002);
        // R7: edge source through edge mask
        rd(8'h00, r); check("R7 unmasked event no status", r, 32'h0);
        wr(8'h5c, 32'h0000_0002);
        rd(8'h00, r); check("R7 masked-in event status", r, 32'h1);
        wr(8'h58, 32'h0000_0002);
        rd(8'h00, r); check("R7 status after clear", r, 32'h0);
        wr(8'h04, 32'h0);

        // R6: new edge beats a clear in the same cycle
        @(negedge clk); pin_in[0] = 1'b1;
        settle(4);
        @(negedge clk); pin_in[0] = 1'b0;
        settle(4);
        rd(8'h58, r); check("R6 setup event", r, 32'h0000_0001);
        @(negedge clk); pin_in[0] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_addr = 8'h58; bus_wdata = 32'h1; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
        rd(8'h58, r); check("R6 edge wins over clear", r, 32'h0000_0001);
        wr(8'h58, 32'h1);
        rd(8'h58, r); check("R6 clear without edge", r, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule